// File: doc/BRIEF.md
# Interrupt Event Capture and Mask Bank

This block is the event-capture front of a serial bus controller. It turns single-cycle event pulses from the bus engine (no-acknowledge, arbitration loss, transfer completion and the four receive/transmit data-request events) into sticky status bits. It provides two read views of those bits: an unmasked one, which also shows a live bus-busy level, and a masked one. It drives one interrupt line from the masked view.

Software sees a flat 16-bit register port with word addresses. Status bits are cleared by writing ones to them. Interrupt enables are never written directly: one address sets enable bits and another clears them, so a driver can change one source without a read-modify-write. A soft-reset handshake is also held here. A soft-reset request clears the whole bank. A reset-done flag then rises only after the module-enable bit has been held for a fixed number of cycles.

Top module: `evt_irq_bank`

## Requirements
- R1: An event pulse on `ev_pulse[i]` sets status bit i at the next clock edge. The bit order is: 0 no-acknowledge, 1 arbitration lost, 2 transfer complete, 3 receive ready, 4 transmit ready, 5 receive draining, 6 transmit draining.
- R2: A write to address 1 clears every status bit whose `wdata` bit is 1 and leaves the bits written with 0 unchanged. Several bits can be cleared in one write.
- R3: If an event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R4: Writing ones to address 3 sets those enable bits, and writing ones to address 4 clears them. Reading either address returns the current enables in bits 6:0.
- R5: Address 1 reads the status ANDed with the enables. Address 2 reads the whole status plus the live `bus_busy` level in bit 12. Writes to address 2 have no effect.
- R6: `irq` is high exactly when some status bit is set with its enable set. `bus_busy` never raises `irq`.
- R7: Bit 15 of address 0 is the module-enable bit. It is written and read back there, and all other bits of address 0 read 0.
- R8: Writing 1 to bit 0 of address 5 (soft reset) clears status, enables, module enable and reset-done at the next edge. Events in that same cycle are dropped.
- R9: Bit 0 of address 6 (reset-done) rises after DONE_CYC consecutive clock edges with module enable set. It stays set until the next reset. Clearing module enable before then restarts the count.
- R10: After a synchronous reset (`rst_n` low at an edge), every readable field is 0 and `irq` is low.
- R11: Addresses 5 and 7 read 0. Writes there, other than the soft-reset bit, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_pulse | input | 7 | Event pulses from the bus engine, bit order as in R1 |
| bus_busy | input | 1 | Live bus-busy level, shown in the raw view only |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check several rules on every cycle:
- event capture and the precedence of an event over a same-cycle clear;
- that a write-one clear takes effect;
- that set and clear writes to the enables take effect;
- that a soft reset wipes status, enables and reset-done;
- that reset-done only rises while the module is enabled and then holds.

The masked and raw read views, the interrupt line, the busy bit's exclusion from the interrupt, ignored writes and the exact cycle on which reset-done appears can only be shown by the bench. It compares every port read against its own model, under directed cases and seeded random traffic.

// File: rtl/evt_irq_pkg.sv
// Shared constants for the interrupt event bank: register word addresses
// and event bit positions. Assumes a 3-bit word address space.
package evt_irq_pkg;
    localparam int ADDR_W = 3;
    localparam int NUM_EV = 7;

    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT    = 3'd1;
    localparam logic [ADDR_W-1:0] A_RAW     = 3'd2;
    localparam logic [ADDR_W-1:0] A_ENSET   = 3'd3;
    localparam logic [ADDR_W-1:0] A_ENCLR   = 3'd4;
    localparam logic [ADDR_W-1:0] A_SYSCTL  = 3'd5;
    localparam logic [ADDR_W-1:0] A_SYSSTAT = 3'd6;

    localparam int EV_NOACK   = 0;
    localparam int EV_ARBLOST = 1;
    localparam int EV_XFER    = 2;
    localparam int EV_RXRDY   = 3;
    localparam int EV_TXRDY   = 4;
    localparam int EV_RXDRAIN = 5;
    localparam int EV_TXDRAIN = 6;

    localparam int SRST_BIT = 0;
    localparam int DONE_BIT = 0;
endpackage

// File: rtl/evt_status_reg.sv
// Sticky event status register. Each bit is set by its event pulse and
// cleared by a write-one clear. An event wins over a same-cycle clear.
// A soft reset clears every bit and drops same-cycle events.
// Assumes event pulses are synchronous to clk.
module evt_status_reg #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic [N-1:0] ev,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] stat
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // Update one status bit: reset, then event, then clear.
        always_ff @(posedge clk) begin
            if (!rst_n || srst)
                stat[i] <= 1'b0;
            else if (ev[i])
                stat[i] <= 1'b1;
            else if (clr_we && clr_mask[i])
                stat[i] <= 1'b0;
        end
    end

    // R1 and R3: an event always leaves its bit set, even against a clear.
    a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && (ev != '0)) |=> ((stat & $past(ev)) == $past(ev)));

    // R2: cleared bits without a concurrent event read zero.
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!srst && clr_we) |=> ((stat & $past(clr_mask & ~ev)) == '0));

    // R8: soft reset empties the register.
    a_r8_stat_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (stat == '0));
endmodule

// File: rtl/evt_enable_reg.sv
// Interrupt enable register changed only through set and clear strobes.
// Assumes set and clear never arrive in the same cycle (distinct addresses).
module evt_enable_reg #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         srst,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [N-1:0] wmask,
    output logic [N-1:0] en
);
    // Apply set or clear masks to the enables.
    always_ff @(posedge clk) begin
        if (!rst_n || srst)
            en <= '0;
        else if (set_we)
            en <= en | wmask;
        else if (clr_we)
            en <= en & ~wmask;
    end

    // R4: set strobe raises the written bits.
    a_r4_set: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !srst) |=> ((en & $past(wmask)) == $past(wmask)));

    // R4: clear strobe lowers the written bits.
    a_r4_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !srst) |=> ((en & $past(wmask)) == '0));

    // R8: soft reset drops all enables.
    a_r8_en_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (en == '0));
endmodule

// File: rtl/evt_reset_seq.sv
// Soft-reset completion tracker. After a reset the done flag is low.
// It rises once the module enable has been high for DONE_CYC consecutive
// edges and then holds. Dropping the enable early restarts the count.
module evt_reset_seq #(
    parameter int DONE_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic mod_en,
    output logic done
);
    localparam int CW = $clog2(DONE_CYC + 1);

    logic [CW-1:0] cnt;

    // Count enabled cycles until done, then freeze.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (!done) begin
            if (mod_en) begin
                cnt <= cnt + 1'b1;
                if (cnt == CW'(DONE_CYC - 1))
                    done <= 1'b1;
            end else begin
                cnt <= '0;
            end
        end
    end

    // R9: done only rises while the module is enabled.
    a_r9_rise_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mod_en));

    // R9: done holds until a reset.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !srst) |=> done);

    // R8: soft reset lowers done.
    a_r8_done_wipe: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> !done);
endmodule

// File: rtl/evt_irq_bank.sv
// Interrupt event capture and mask bank, top level. It decodes a 16-bit
// word-addressed register port, holds the module-enable bit, builds the
// raw and masked read views and drives irq. Reads are combinational.
// Assumes one access per cycle.
module evt_irq_bank
    import evt_irq_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_EVT  = NUM_EV,
    parameter int DONE_CYC = 4,
    parameter int EN_BIT   = 15,
    parameter int BUSY_BIT = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] ev_pulse,
    input  logic               bus_busy,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq
);
    localparam logic [DATA_W-1:0] USED_MASK =
        DATA_W'((1 << NUM_EVT) - 1) | (DATA_W'(1) << EN_BIT) | (DATA_W'(1) << SRST_BIT);

    logic               srst;
    logic               ctrl_en;
    logic               done;
    logic [NUM_EVT-1:0] stat_q;
    logic [NUM_EVT-1:0] en_q;
    logic [NUM_EVT-1:0] masked;
    logic               unused_wbits;

    assign srst         = wr_en && (addr == A_SYSCTL) && wdata[SRST_BIT];
    assign masked       = stat_q & en_q;
    assign irq          = |masked;
    assign unused_wbits = ^(wdata & ~USED_MASK);

    // Hold the module-enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n || srst)
            ctrl_en <= 1'b0;
        else if (wr_en && (addr == A_CTRL))
            ctrl_en <= wdata[EN_BIT];
    end

    evt_status_reg #(.N(NUM_EVT)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .srst     (srst),
        .ev       (ev_pulse),
        .clr_we   (wr_en && (addr == A_STAT)),
        .clr_mask (wdata[NUM_EVT-1:0]),
        .stat     (stat_q)
    );

    evt_enable_reg #(.N(NUM_EVT)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .srst   (srst),
        .set_we (wr_en && (addr == A_ENSET)),
        .clr_we (wr_en && (addr == A_ENCLR)),
        .wmask  (wdata[NUM_EVT-1:0]),
        .en     (en_q)
    );

    evt_reset_seq #(.DONE_CYC(DONE_CYC)) u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .srst   (srst),
        .mod_en (ctrl_en),
        .done   (done)
    );

    // Select the read view for the addressed register.
    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL:    rdata[EN_BIT] = ctrl_en;
            A_STAT:    rdata[NUM_EVT-1:0] = masked;
            A_RAW: begin
                rdata[NUM_EVT-1:0] = stat_q;
                rdata[BUSY_BIT]    = bus_busy;
            end
            A_ENSET,
            A_ENCLR:   rdata[NUM_EVT-1:0] = en_q;
            A_SYSSTAT: rdata[DONE_BIT] = done;
            default:   rdata = '0;
        endcase
    end

    // R7: a control write lands in the module-enable bit.
    a_r7_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_CTRL)) |=> (ctrl_en == $past(wdata[EN_BIT])));
endmodule

// File: tb/evt_irq_bank_test.sv
`timescale 1ns/1ps
module evt_irq_bank_test;
    localparam int DONE_CYC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  ev_pulse = '0;
    logic        bus_busy = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // Bench model state
    logic [6:0] m_stat = '0;
    logic [6:0] m_en   = '0;
    logic       m_ctrl = 1'b0;
    logic       m_done = 1'b0;
    int         m_cnt  = 0;

    always #2 clk = ~clk;

    evt_irq_bank #(.DONE_CYC(DONE_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .bus_busy(bus_busy),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic logic [15:0] exp_read(input logic [2:0] a);
        logic [15:0] r = '0;
        case (a)
            3'd0: r[15] = m_ctrl;
            3'd1: r[6:0] = m_stat & m_en;
            3'd2: begin r[6:0] = m_stat; r[12] = bus_busy; end
            3'd3, 3'd4: r[6:0] = m_en;
            3'd6: r[0] = m_done;
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic model_step(input logic [6:0] ev, input logic wr,
                              input logic [2:0] a, input logic [15:0] d);
        logic old_ctrl = m_ctrl;
        if (!rst_n || (wr && a == 3'd5 && d[0])) begin
            m_stat = '0; m_en = '0; m_ctrl = 1'b0; m_done = 1'b0; m_cnt = 0;
        end else begin
            m_stat = (m_stat & ~((wr && a == 3'd1) ? d[6:0] : 7'd0)) | ev;
            if (wr && a == 3'd3) m_en = m_en | d[6:0];
            if (wr && a == 3'd4) m_en = m_en & ~d[6:0];
            if (wr && a == 3'd0) m_ctrl = d[15];
            if (!m_done) begin
                if (old_ctrl) begin
                    m_cnt++;
                    if (m_cnt == DONE_CYC) m_done = 1'b1;
                end else m_cnt = 0;
            end
        end
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [6:0] ev, input logic wr,
                       input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        ev_pulse = ev; wr_en = wr; addr = a; wdata = d;
        @(posedge clk);
        model_step(ev, wr, a, d);
    endtask

    task automatic rdchk(input logic [2:0] a, input string req);
        @(negedge clk);
        ev_pulse = '0; wr_en = 1'b0; addr = a; wdata = '0;
        #1;
        check(req, rdata, exp_read(a));
        check("R6 irq", {15'd0, irq}, {15'd0, |(m_stat & m_en)});
        @(posedge clk);
        model_step(7'd0, 1'b0, a, 16'd0);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R10 reset state
        for (int a = 0; a < 8; a++) rdchk(3'(a), "R10 reset value");

        // R1 capture, unmasked
        cyc(7'h08, 0, 0, 0);
        rdchk(3'd2, "R1 raw capture");
        rdchk(3'd1, "R5 masked while disabled");
        // R4 set enables, masked view and irq
        cyc(0, 1, 3'd3, 16'h0008);
        rdchk(3'd1, "R5 masked after enable");
        rdchk(3'd4, "R4 enables read at clear address");
        // R2 clear
        cyc(0, 1, 3'd1, 16'h0008);
        rdchk(3'd2, "R2 w1c clears bit");
        // R2 zero bits untouched, multiple bits
        cyc(7'h45, 0, 0, 0);
        cyc(0, 1, 3'd1, 16'h0001);
        rdchk(3'd2, "R2 zero bits unchanged");
        cyc(0, 1, 3'd1, 16'h0044);
        rdchk(3'd2, "R2 multi-bit clear");
        // R3 collision
        cyc(7'h04, 0, 0, 0);
        cyc(7'h04, 1, 3'd1, 16'h0004);
        rdchk(3'd2, "R3 event beats clear");
        // R5 raw write ignored
        cyc(0, 1, 3'd2, 16'hffff);
        rdchk(3'd2, "R5 raw write ignored");
        // R6 busy not interrupting
        cyc(0, 1, 3'd1, 16'h007f);
        bus_busy = 1'b1;
        cyc(0, 1, 3'd3, 16'h007f);
        rdchk(3'd2, "R5 busy in raw view");
        rdchk(3'd1, "R6 busy absent from masked view");
        bus_busy = 1'b0;
        // R4 clear enables
        cyc(7'h30, 1, 3'd4, 16'h0010);
        rdchk(3'd3, "R4 clear enables");
        rdchk(3'd1, "R4 masked after clear");
        // R11 other addresses
        cyc(0, 1, 3'd7, 16'hffff);
        cyc(0, 1, 3'd5, 16'hfffe);
        rdchk(3'd7, "R11 unused address reads 0");
        rdchk(3'd5, "R11 sysctl reads 0");
        rdchk(3'd2, "R11 status unchanged");
        rdchk(3'd3, "R11 enables unchanged");
        // R7 control
        cyc(0, 1, 3'd0, 16'hffff);
        rdchk(3'd0, "R7 enable bit readback");
        // R8 soft reset with same-cycle event
        cyc(7'h7f, 1, 3'd5, 16'h0001);
        for (int a = 0; a < 7; a++) rdchk(3'(a), "R8 soft reset wipe");
        // R9 done timing, with one early drop of enable
        cyc(0, 1, 3'd0, 16'h8000);
        rdchk(3'd6, "R9 done timing");
        cyc(0, 1, 3'd0, 16'h0000);
        cyc(0, 1, 3'd0, 16'h8000);
        for (int k = 0; k < DONE_CYC + 3; k++) rdchk(3'd6, "R9 done timing");
        cyc(0, 1, 3'd0, 16'h0000);
        rdchk(3'd6, "R9 done holds");

        // Random phase
        for (int k = 0; k < 1500; k++) begin
            logic [6:0] ev = 7'($urandom) & 7'($urandom) & 7'($urandom);
            logic [2:0] a = 3'($urandom);
            logic [15:0] d = 16'($urandom);
            logic wr = ($urandom % 3) == 0;
            if (a == 3'd5 && ($urandom % 6) != 0) d[0] = 1'b0;
            if (($urandom % 16) == 0) bus_busy = ~bus_busy;
            cyc(ev, wr, a, d);
            rdchk(3'($urandom), "R1-R9 random mix");
        end

        // Synchronous reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); model_step(0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1; bus_busy = 1'b0;
        for (int a = 0; a < 8; a++) rdchk(3'(a), "R10 reset after traffic");

        finish_run();
    end
endmodule